// File: doc/BRIEF.md
# VGA Scanout with Chunked Ping-Pong Prefetch

This block produces 640x480 VGA raster timing at a 25.175 MHz pixel clock and streams pixels held in SDRAM to a 24-bit RGB output. Pixels are 32-bit words whose low 24 bits carry 8:8:8 colour. A visible line is cut into chunks of 128 pixels. The block owns a small two-half line buffer. While one half is shown, a burst read for the next chunk is asked of an external SDRAM burst engine, which fills the other half through a write port.

Requests go through a single command slot. The block writes an SDRAM address and a control word. The engine reads the control word back as nonzero while the transfer runs and clears it to zero when the transfer is done. The block places a new request only after it has seen the slot read back as zero. One request primes the buffer at the start of each field. Each further request is made at the start of a displayed chunk and fetches the chunk that follows it.

Top module: `vga_chunk_scanout`

## Requirements
- R1: A line lasts H_FP+H_SYNC+H_BP+H_ACT clocks, in the order front porch, sync, back porch, active; `hsync_n` is low for exactly the H_SYNC sync clocks.
- R2: A frame lasts V_TOP+V_ACT+V_BOT+V_SYNC lines, in the order top blank, visible, bottom blank, sync; `vsync_n` is low only during the last V_SYNC lines.
- R3: On the first clock of each field the address pointer restarts. The next request carries address 0 and control CTRL_BASE, which selects buffer half 0.
- R4: Each later request in a field carries the previous address plus ADDR_STEP. Its control word alternates between CTRL_BASE and CTRL_BASE^CTRL_TOGGLE. One request is owed at the first clock of every active chunk of every visible line, so a field holds 1+CHUNKS_PER_LINE*V_ACT requests.
- R5: `req_valid` is never asserted in a cycle that follows a cycle in which `slot_ctrl` was nonzero. A request owed while the slot is busy is held pending. It issues one clock after the slot is seen to be zero.
- R6: The k-th chunk of a field (k from 0) shows buffer half k mod 2. Pixel i of the chunk is the low 24 bits of the word at buffer index i, so it shows the data fetched by request k.
- R7: `rgb` is zero in every clock outside the active region.
- R8: All outputs lag the raster counters by one clock. In reset, `hsync_n`=1, `vsync_n`=1, `rgb`=0 and `req_valid`=0.
- R9: Buffer write address bit CHUNK_LOG2 selects the half, and the lower bits give the pixel index. The engine writes half 1 when the request's control word has the CTRL_TOGGLE bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_ctrl | input | CW | Control word read back from the command slot; zero when free |
| req_valid | output | 1 | One-clock pulse writing a request into the slot |
| req_addr | output | AW | SDRAM address of the requested chunk |
| req_ctrl | output | CW | Control word, including the target buffer half |
| buf_we | input | 1 | Line buffer write enable from the burst engine |
| buf_waddr | input | CHUNK_LOG2+1 | Line buffer write address {half, index} |
| buf_wdata | input | 32 | Pixel word written to the buffer |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 24 | Pixel colour, zero outside the active region |

## Verification
The hardest case is a request that falls due while the slot still reads busy. The request must be held and then issued late, and the late fill must still not damage the display. The bench holds the slot busy for ten clocks across the priming request after reset. Its burst-engine model takes longer than one chunk to finish each transfer, so within a line most requests are deferred naturally. Every output clock over three fields is compared against a scoreboard computed from the SDRAM pattern. This shows that the deferred fills land in the correct half before they are shown.

// File: rtl/vga_chunk_scanout.sv
module vga_chunk_scanout #(
  parameter int CHUNK_LOG2 = 7,
  parameter int CHUNKS_PER_LINE = 5,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_TOP = 33,
  parameter int V_ACT = 480,
  parameter int V_BOT = 10,
  parameter int V_SYNC = 2,
  parameter int AW = 32,
  parameter int CW = 32,
  parameter logic [AW-1:0] ADDR_STEP = 'h200,
  parameter logic [CW-1:0] CTRL_BASE = 'h1006,
  parameter logic [CW-1:0] CTRL_TOGGLE = 'h200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CW-1:0]         slot_ctrl,
  output logic                  req_valid,
  output logic [AW-1:0]         req_addr,
  output logic [CW-1:0]         req_ctrl,
  input  logic                  buf_we,
  input  logic [CHUNK_LOG2:0]   buf_waddr,
  input  logic [31:0]           buf_wdata,
  output logic                  hsync_n,
  output logic                  vsync_n,
  output logic [23:0]           rgb
);
  localparam int CHUNK   = 1 << CHUNK_LOG2;
  localparam int H_ACT   = CHUNK * CHUNKS_PER_LINE;
  localparam int H_BLANK = H_FP + H_SYNC + H_BP;
  localparam int H_TOTAL = H_BLANK + H_ACT;
  localparam int V_TOTAL = V_TOP + V_ACT + V_BOT + V_SYNC;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic pending, nxt_half, disp_half, act_q;
  logic [AW-1:0] ptr;
  logic [31:0] mem [2*CHUNK];
  logic [31:0] rd_q;

  wire h_end = h == HW'(H_TOTAL - 1);
  wire v_end = v == VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h <= '0;
      v <= '0;
    end else begin
      h <= h_end ? '0 : h + 1'b1;
      if (h_end) v <= v_end ? '0 : v + 1'b1;
    end
  end

  wire v_vis  = v >= VW'(V_TOP) && v < VW'(V_TOP + V_ACT);
  wire active = v_vis && h >= HW'(H_BLANK);
  wire [HW-1:0] col = h - HW'(H_BLANK);
  wire [CHUNK_LOG2-1:0] pix = col[CHUNK_LOG2-1:0];
  wire field_start = h == '0 && v == '0;
  wire chunk_start = active && pix == '0;
  wire chunk_last  = active && &pix;
  wire want        = field_start || chunk_start || pending;
  wire [AW-1:0] cur_addr = field_start ? '0 : ptr;
  wire cur_half = field_start ? 1'b0 : nxt_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      nxt_half <= 1'b0;
      pending <= 1'b0;
      req_valid <= 1'b0;
      req_addr <= '0;
      req_ctrl <= '0;
    end else begin
      req_valid <= 1'b0;
      if (field_start) begin
        ptr <= '0;
        nxt_half <= 1'b0;
      end
      if (want && slot_ctrl == '0) begin
        req_valid <= 1'b1;
        req_addr  <= cur_addr;
        req_ctrl  <= cur_half ? (CTRL_BASE ^ CTRL_TOGGLE) : CTRL_BASE;
        ptr       <= cur_addr + ADDR_STEP;
        nxt_half  <= ~cur_half;
        pending   <= 1'b0;
      end else if (want) begin
        pending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_waddr] <= buf_wdata;
    rd_q <= mem[{disp_half, pix}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_half <= 1'b0;
      act_q <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      if (field_start) disp_half <= 1'b0;
      else if (chunk_last) disp_half <= ~disp_half;
      act_q <= active;
      hsync_n <= !(h >= HW'(H_FP) && h < HW'(H_FP + H_SYNC));
      vsync_n <= !(v >= VW'(V_TOP + V_ACT + V_BOT));
    end
  end

  assign rgb = act_q ? rd_q[23:0] : 24'h0;
endmodule

// File: rtl/vga_chunk_scanout_chk.sv
module vga_chunk_scanout_chk #(
  parameter int H_SYNC = 96,
  parameter int AW = 32,
  parameter int CW = 32,
  parameter logic [CW-1:0] CTRL_BASE = 'h1006,
  parameter logic [CW-1:0] CTRL_TOGGLE = 'h200
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] slot_ctrl,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [CW-1:0] req_ctrl,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [23:0]   rgb
);
  logic [15:0] lo_cnt;
  logic [CW-1:0] last_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      last_ctrl <= '0;
    end else begin
      lo_cnt <= hsync_n ? '0 : lo_cnt + 1'b1;
      if (req_valid) last_ctrl <= req_ctrl;
    end
  end

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> lo_cnt == 16'(H_SYNC));
  assert_blank_in_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> rgb == '0);
  assert_prime_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == '0) |-> req_ctrl == CTRL_BASE);
  assert_ctrl_alternates_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr != '0) |-> req_ctrl == (last_ctrl ^ CTRL_TOGGLE));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  assert_wait_free_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(slot_ctrl) == '0);
endmodule

bind vga_chunk_scanout vga_chunk_scanout_chk #(
  .H_SYNC(H_SYNC), .AW(AW), .CW(CW), .CTRL_BASE(CTRL_BASE), .CTRL_TOGGLE(CTRL_TOGGLE)
) u_chk (.*);

// File: tb/vga_chunk_scanout_tb.sv
module vga_chunk_scanout_tb;
  localparam int CL = 4, CPL = 3, CHUNK = 1 << CL;
  localparam int FP = 4, SY = 6, BP = 5, HB = FP + SY + BP, HT = HB + CHUNK * CPL;
  localparam int VTOP = 3, VACT = 4, VBOT = 2, VSY = 2, VT = VTOP + VACT + VBOT + VSY;
  localparam int FT = HT * VT, FIELDS = 3, HOLD = 10;
  localparam logic [31:0] STEP = 32'h200, BASE = 32'h1006, TOG = 32'h200;

  logic clk = 0, rst = 1, hold = 1, done = 0;
  logic req_valid, buf_we, hsync_n, vsync_n;
  logic [31:0] slot_ctrl, req_addr, req_ctrl, buf_wdata;
  logic [CL:0] buf_waddr;
  logic [23:0] rgb;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vga_chunk_scanout #(.CHUNK_LOG2(CL), .CHUNKS_PER_LINE(CPL), .H_FP(FP), .H_SYNC(SY), .H_BP(BP),
    .V_TOP(VTOP), .V_ACT(VACT), .V_BOT(VBOT), .V_SYNC(VSY)) u_dut (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    logic [31:0] m = a * 32'd40503 + 32'd17;
    return {8'hC3, m[23:0]};
  endfunction

  // burst engine model: busy for the whole fill, writes one word per clock
  logic busy = 0;
  logic [31:0] cur_addr, cur_ctrl;
  int cnt;
  assign slot_ctrl = hold ? 32'hFFFF : (busy ? cur_ctrl : 32'h0);
  always @(posedge clk) begin
    if (rst) begin
      busy <= 0; buf_we <= 0; buf_waddr <= '0; buf_wdata <= '0; cnt <= 0;
    end else if (!busy) begin
      buf_we <= 0;
      if (req_valid) begin
        busy <= 1; cur_addr <= req_addr; cur_ctrl <= req_ctrl; cnt <= 0;
      end
    end else if (cnt < CHUNK) begin
      buf_we <= 1;
      buf_waddr <= {((cur_ctrl & TOG) != 0), CL'(cnt)};
      buf_wdata <= pat(cur_addr + 32'(cnt));
      cnt <= cnt + 1;
    end else begin
      buf_we <= 0; busy <= 0;
    end
  end

  logic [25:0] exp_q[$];
  logic [63:0] req_q[$];

  task automatic push_field();
    for (int n = 0; n < FT; n++) begin
      int h = n % HT, v = n / HT;
      logic hs = !(h >= FP && h < FP + SY);
      logic vs = !(v >= VTOP + VACT + VBOT);
      logic [23:0] px = 24'h0;
      if (v >= VTOP && v < VTOP + VACT && h >= HB) begin
        int k = (v - VTOP) * CPL + (h - HB) / CHUNK;
        logic [31:0] w = pat(32'(k) * STEP + 32'((h - HB) % CHUNK));
        px = w[23:0];
      end
      exp_q.push_back({hs, vs, px});
    end
    for (int r = 0; r <= CPL * VACT; r++)
      req_q.push_back({32'(r) * STEP, (r % 2 == 1) ? (BASE ^ TOG) : BASE});
  endtask

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    repeat (FIELDS * FT + 2000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rq_idx = 0;
    for (int f = 0; f < FIELDS; f++) push_field();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hsync_n && vsync_n && rgb == 0 && !req_valid, "R8 reset state",
          {hsync_n, vsync_n, rgb, req_valid}, {1'b1, 1'b1, 24'h0, 1'b0});
    rst = 0;
    for (int n = 0; n < FIELDS * FT; n++) begin
      logic [25:0] e;
      @(negedge clk);
      // monitor: one-clock output latency (R8) puts position n here
      e = exp_q.pop_front();
      if (hsync_n !== e[25]) check(0, "R1 hsync", 64'(hsync_n), 64'(e[25]));
      else if (vsync_n !== e[24]) check(0, "R2 vsync", 64'(vsync_n), 64'(e[24]));
      else if (rgb !== e[23:0]) check(0, (e[23:0] == 0) ? "R7 rgb blank" : "R6/R9 pixel",
                                      64'(rgb), 64'(e[23:0]));
      else check(1, "", 0, 0);
      if (n < HOLD) check(!req_valid, "R5 request while slot busy", 64'(req_valid), 0);
      if (n == HOLD - 1) hold = 0;
      if (n == HOLD) check(req_valid, "R5 request one clock after slot free", 64'(req_valid), 1);
      if (req_valid) begin
        logic [63:0] r;
        if (req_q.size() == 0) begin
          check(0, "R4 extra request", 64'(req_addr), 0);
        end else begin
          r = req_q.pop_front();
          check({req_addr, req_ctrl} == r, (r[63:32] == 0) ? "R3 prime request" : "R4 chunk request",
                {req_addr, req_ctrl}, r);
        end
        rq_idx++;
      end
    end
    check(req_q.size() == 0, "R4 requests per field", 64'(rq_idx), 64'(FIELDS * (1 + CPL * VACT)));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule